// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block sits on the host side of a NOR-style parallel flash. It takes one request at a time: program a word, erase a sector, erase a block, or erase the whole chip. It then issues the unlock-and-command write series that the flash expects, as ordinary write transactions on a simple synchronous bus master port.

Once the last command write is accepted, the block polls a status address of the flash. It watches the toggling status bit (bit 6 of the read word) until two reads in a row agree. Because one status read can land on the very end of the internal operation, a match is trusted only after two more reads that agree with it.

A program operation ends with a read-back of the word, which is compared with the data written. A poll budget counted in status reads bounds the wait. The result comes back as a one-cycle done pulse with a fail qualifier.

Top module: `fpe_sequencer`

## Requirements
- R1: After reset, req_ready is 1, bus_req is 0 and done is 0.
- R2: A program request (req_op = 0) produces four bus writes, in this order: (555h, 00AAh), (2AAh, 0055h), (555h, 00A0h), then (req_addr, req_data).
- R3: An erase request produces six bus writes: (555h, AAh), (2AAh, 55h), (555h, 80h), (555h, AAh), (2AAh, 55h), then a final write. The final write depends on req_op:
  - req_op = 1 (sector erase) writes 30h to req_addr with its low SECT_LSB bits cleared.
  - req_op = 2 (block erase) writes 50h to req_addr with its low BLK_LSB bits cleared.
  - req_op = 3 (chip erase) writes 10h to 555h.
- R4: A request is taken when req_valid and req_ready are both 1. From then until its done pulse, req_ready stays 0, further requests are neither taken nor acted on, and no bus transaction is started while req_ready is 1.
- R5: Once bus_req is raised, bus_req, bus_we, bus_addr and bus_wdata hold steady until a cycle with bus_ack. Each acknowledged cycle completes exactly one transaction.
- R6: Every status read, and the program read-back, uses a fixed address:
  - program: req_addr;
  - sector and block erase: the aligned base used in the final write;
  - chip erase: address 0.
- R7: A bit-6 match between two consecutive status reads is followed by two more status reads. The operation counts as finished only if both extra reads show that same bit-6 value. Otherwise polling resumes and no done pulse is given.
- R8: Every status read that does not finish the operation counts toward POLL_LIMIT. When POLL_LIMIT such reads have been made, done pulses with fail = 1 and no further read is issued.
- R9: After a program finishes, one read of req_addr is made. fail is 1 exactly when that word differs from req_data.
- R10: A finished erase gives done with fail = 0 and makes no read-back.
- R11: done is high for exactly one cycle per request, and fail is 0 whenever done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | ADDR_W | Word address to program, or an address inside the region to erase |
| req_data | input | DATA_W | Word to program |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | With done: timeout or read-back mismatch |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Transaction complete; read data valid in this cycle |
| bus_rdata | input | DATA_W | Read data |

## Verification
Assertions watch four things on every cycle:
- the bus request holding steady until acknowledged;
- the single-cycle done pulse and the fail qualifier;
- the ready/busy relation around request acceptance;
- the poll counter never exceeding its budget.

Only the bench scenarios can show the rest: the exact command words and addresses, the status address for each erase kind, the confirmation after a status read that lands during a busy period, the exact number of reads before a timeout, and the read-back result. The bench does this against a behavioural flash that toggles its status bit while busy.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } fpe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CMD    = 3'd1,
        ST_POLL0  = 3'd2,
        ST_POLL   = 3'd3,
        ST_CONF1  = 3'd4,
        ST_CONF2  = 3'd5,
        ST_VERIFY = 3'd6,
        ST_FINISH = 3'd7
    } fpe_state_e;

    localparam int STEP_W     = 3;
    localparam int TOGGLE_BIT = 6;
    localparam int LOW_ADDR_W = 12;

    localparam logic [LOW_ADDR_W-1:0] UNLOCK_ADDR_A = 12'h555;
    localparam logic [LOW_ADDR_W-1:0] UNLOCK_ADDR_B = 12'h2AA;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] CODE_PROG   = 8'hA0;
    localparam logic [7:0] CODE_ESETUP = 8'h80;
    localparam logic [7:0] CODE_SECT   = 8'h30;
    localparam logic [7:0] CODE_BLK    = 8'h50;
    localparam logic [7:0] CODE_CHIP   = 8'h10;

endpackage

// File: rtl/fpe_cmd_gen.sv
module fpe_cmd_gen
    import fpe_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  fpe_op_e             op,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic [DATA_W-1:0]   tgt_data,
    input  logic [STEP_W-1:0]   step,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                last_step,
    output logic [ADDR_W-1:0]   status_addr
);

    localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
    localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;
    localparam logic [ADDR_W-1:0] ADDR_A    = {{(ADDR_W-LOW_ADDR_W){1'b0}}, UNLOCK_ADDR_A};
    localparam logic [ADDR_W-1:0] ADDR_B    = {{(ADDR_W-LOW_ADDR_W){1'b0}}, UNLOCK_ADDR_B};
    localparam logic [STEP_W-1:0] PROG_LAST  = STEP_W'(3);
    localparam logic [STEP_W-1:0] ERASE_LAST = STEP_W'(5);

    function automatic logic [DATA_W-1:0] code_word(input logic [7:0] c);
        return {{(DATA_W-8){1'b0}}, c};
    endfunction

    logic [ADDR_W-1:0] region_addr;
    logic [7:0]        final_code;

    always_comb begin
        case (op)
            OP_SECT: begin region_addr = tgt_addr & SECT_MASK; final_code = CODE_SECT; end
            OP_BLK:  begin region_addr = tgt_addr & BLK_MASK;  final_code = CODE_BLK;  end
            OP_CHIP: begin region_addr = '0;                   final_code = CODE_CHIP; end
            default: begin region_addr = tgt_addr;             final_code = CODE_PROG; end
        endcase
    end

    always_comb begin
        wr_addr   = ADDR_A;
        wr_data   = code_word(KEY_FIRST);
        last_step = 1'b0;
        if (op == OP_PROG) begin
            case (step)
                STEP_W'(0): begin wr_addr = ADDR_A; wr_data = code_word(KEY_FIRST);  end
                STEP_W'(1): begin wr_addr = ADDR_B; wr_data = code_word(KEY_SECOND); end
                STEP_W'(2): begin wr_addr = ADDR_A; wr_data = code_word(CODE_PROG);  end
                default:    begin wr_addr = tgt_addr; wr_data = tgt_data;            end
            endcase
            last_step = (step == PROG_LAST);
        end else begin
            case (step)
                STEP_W'(0): begin wr_addr = ADDR_A; wr_data = code_word(KEY_FIRST);   end
                STEP_W'(1): begin wr_addr = ADDR_B; wr_data = code_word(KEY_SECOND);  end
                STEP_W'(2): begin wr_addr = ADDR_A; wr_data = code_word(CODE_ESETUP); end
                STEP_W'(3): begin wr_addr = ADDR_A; wr_data = code_word(KEY_FIRST);   end
                STEP_W'(4): begin wr_addr = ADDR_B; wr_data = code_word(KEY_SECOND);  end
                default: begin
                    wr_addr = (op == OP_CHIP) ? ADDR_A : region_addr;
                    wr_data = code_word(final_code);
                end
            endcase
            last_step = (step == ERASE_LAST);
        end
    end

    assign status_addr = region_addr;

endmodule

// File: rtl/fpe_toggle_judge.sv
module fpe_toggle_judge (
    input  logic cur_bit,
    input  logic prev_bit,
    input  logic conf_bit,
    output logic match_prev,
    output logic confirm_ok
);

    always_comb begin
        match_prev = (cur_bit == prev_bit);
        confirm_ok = match_prev && (conf_bit == prev_bit);
    end

endmodule

// File: rtl/fpe_poll_timer.sv
module fpe_poll_timer #(
    parameter int POLL_LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic expired
);

    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        expired = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d   = cnt_q + CNT_W'(1);
            expired = (int'(cnt_q) + 1 >= POLL_LIMIT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_POLL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= POLL_LIMIT); // R8

endmodule

// File: rtl/fpe_sequencer.sv
module fpe_sequencer
    import fpe_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int SECT_LSB   = 11,
    parameter int BLK_LSB    = 15,
    parameter int POLL_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              done,
    output logic              fail,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    typedef struct packed {
        fpe_state_e          state;
        logic [STEP_W-1:0]   step;
        fpe_op_e             op;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic                prev;
        logic                conf;
        logic                fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              cmd_last;
    logic [ADDR_W-1:0] stat_addr;
    logic              match_prev;
    logic              confirm_ok;
    logic              tmr_clear;
    logic              tmr_tick;
    logic              tmr_expired;

    fpe_cmd_gen #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SECT_LSB(SECT_LSB),
        .BLK_LSB (BLK_LSB)
    ) u_cmd (
        .op         (ctl_q.op),
        .tgt_addr   (ctl_q.addr),
        .tgt_data   (ctl_q.data),
        .step       (ctl_q.step),
        .wr_addr    (cmd_addr),
        .wr_data    (cmd_data),
        .last_step  (cmd_last),
        .status_addr(stat_addr)
    );

    fpe_toggle_judge u_judge (
        .cur_bit   (bus_rdata[TOGGLE_BIT]),
        .prev_bit  (ctl_q.prev),
        .conf_bit  (ctl_q.conf),
        .match_prev(match_prev),
        .confirm_ok(confirm_ok)
    );

    fpe_poll_timer #(
        .POLL_LIMIT(POLL_LIMIT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (tmr_tick),
        .expired(tmr_expired)
    );

    always_comb begin
        ctl_d     = ctl_q;
        tmr_clear = 1'b0;
        tmr_tick  = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = stat_addr;
        bus_wdata = '0;
        req_ready = 1'b0;
        done      = 1'b0;
        fail      = 1'b0;

        case (ctl_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    ctl_d.op    = fpe_op_e'(req_op);
                    ctl_d.addr  = req_addr;
                    ctl_d.data  = req_data;
                    ctl_d.step  = '0;
                    ctl_d.fail  = 1'b0;
                    ctl_d.state = ST_CMD;
                end
            end

            ST_CMD: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = cmd_addr;
                bus_wdata = cmd_data;
                if (bus_ack) begin
                    if (cmd_last) begin
                        tmr_clear   = 1'b1;
                        ctl_d.state = ST_POLL0;
                    end else begin
                        ctl_d.step = ctl_q.step + STEP_W'(1);
                    end
                end
            end

            ST_POLL0: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    tmr_tick   = 1'b1;
                    ctl_d.prev = bus_rdata[TOGGLE_BIT];
                    if (tmr_expired) begin
                        ctl_d.fail  = 1'b1;
                        ctl_d.state = ST_FINISH;
                    end else begin
                        ctl_d.state = ST_POLL;
                    end
                end
            end

            ST_POLL: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    tmr_tick = 1'b1;
                    if (tmr_expired) begin
                        ctl_d.fail  = 1'b1;
                        ctl_d.state = ST_FINISH;
                    end else if (match_prev) begin
                        ctl_d.state = ST_CONF1;
                    end else begin
                        ctl_d.prev = bus_rdata[TOGGLE_BIT];
                    end
                end
            end

            ST_CONF1: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    tmr_tick   = 1'b1;
                    ctl_d.conf = bus_rdata[TOGGLE_BIT];
                    if (tmr_expired) begin
                        ctl_d.fail  = 1'b1;
                        ctl_d.state = ST_FINISH;
                    end else begin
                        ctl_d.state = ST_CONF2;
                    end
                end
            end

            ST_CONF2: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    tmr_tick = 1'b1;
                    if (confirm_ok) begin
                        ctl_d.state = (ctl_q.op == OP_PROG) ? ST_VERIFY : ST_FINISH;
                    end else if (tmr_expired) begin
                        ctl_d.fail  = 1'b1;
                        ctl_d.state = ST_FINISH;
                    end else begin
                        ctl_d.prev  = bus_rdata[TOGGLE_BIT];
                        ctl_d.state = ST_POLL;
                    end
                end
            end

            ST_VERIFY: begin
                bus_req  = 1'b1;
                bus_addr = ctl_q.addr;
                if (bus_ack) begin
                    ctl_d.fail  = (bus_rdata != ctl_q.data);
                    ctl_d.state = ST_FINISH;
                end
            end

            default: begin
                done        = 1'b1;
                fail        = ctl_q.fail;
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_FAIL_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req); // R4

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R4

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready); // R4

endmodule

// File: tb/tb_fpe_sequencer.sv
module tb_fpe_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic        done, fail;
    logic        bus_req, bus_we;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpe_sequencer #(.POLL_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data),
        .done(done), .fail(fail),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int checks = 0;
    int errors = 0;

    logic [35:0] expq[$];
    logic [35:0] exp_w;
    logic [15:0] mem[int];
    int          busy_left = 0;
    int          busy_cfg = 0;
    int          busy_reads = 0;
    int          glitch_at = -1;
    bit          stuck = 0;
    bit          tog = 0;
    int          n_reads = 0;
    bit          exp_busy = 0;
    bit          exp_fail = 0;
    int          cur_op = 0;
    logic [19:0] cur_addr = '0;
    logic [15:0] cur_data = '0;
    logic [19:0] exp_rd = '0;
    int          done_seen = 0;
    string       tag_s = "R2";

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_mem(input int a);
        return mem.exists(a) ? mem[a] : 16'hFFFF;
    endfunction

    task automatic apply_effect();
        case (cur_op)
            0: mem[int'(cur_addr)] = rd_mem(int'(cur_addr)) & cur_data;
            1: foreach (mem[k]) if ((k >> 11) == (int'(cur_addr) >> 11)) mem[k] = 16'hFFFF;
            2: foreach (mem[k]) if ((k >> 15) == (int'(cur_addr) >> 15)) mem[k] = 16'hFFFF;
            default: foreach (mem[k]) mem[k] = 16'hFFFF;
        endcase
        busy_left  = busy_cfg;
        busy_reads = 0;
        tog        = 1'b0;
    endtask

    // behavioural flash on the bus: ack one cycle after a request is seen
    initial forever begin
        @(negedge clk);
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (bus_we) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R4 write while no sequence due", {bus_addr, bus_wdata}, 64'h0);
                end else begin
                    exp_w = expq.pop_front();
                    chk({bus_addr, bus_wdata} == exp_w, tag_s, {bus_addr, bus_wdata}, exp_w);
                    if (expq.size() == 0) apply_effect();
                end
            end else begin
                chk(bus_addr == exp_rd, "R6 read address", bus_addr, exp_rd);
                n_reads++;
                if (stuck || busy_left > 0) begin
                    bus_rdata    = 16'h0000;
                    bus_rdata[6] = tog;
                    if (busy_reads != glitch_at) tog = ~tog;
                    busy_reads++;
                    if (!stuck) busy_left--;
                end else begin
                    bus_rdata = rd_mem(int'(bus_addr));
                end
            end
            bus_ack = 1'b1;
        end
    end

    // per-cycle reference comparison
    initial forever begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            chk(req_ready == !exp_busy, "R4 ready versus busy", req_ready, !exp_busy);
            if (!exp_busy) chk(!bus_req, "R4 bus quiet when idle", bus_req, 0);
            if (done) begin
                chk(fail == exp_fail, tag_s, fail, exp_fail);
                chk(expq.size() == 0, "R3 sequence finished before done", expq.size(), 0);
                chk(stuck || busy_left == 0, "R7 done only after device finished", busy_left, 0);
                exp_busy = 0;
                done_seen++;
            end else begin
                chk(!fail, "R11 fail without done", fail, 0);
            end
        end
    end

    task automatic issue(input int op, input logic [19:0] a, input logic [15:0] d,
                         input int busy, input bit efail, input string tag);
        logic [19:0] fin_a;
        logic [15:0] fin_c;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_op = op; cur_addr = a; cur_data = d; busy_cfg = busy;
        exp_fail = efail; tag_s = tag; n_reads = 0;
        if (op == 0) begin
            expq.push_back({20'h00555, 16'h00AA});
            expq.push_back({20'h002AA, 16'h0055});
            expq.push_back({20'h00555, 16'h00A0});
            expq.push_back({a, d});
            exp_rd = a;
        end else begin
            case (op)
                1:       begin fin_a = a & 20'hFF800; fin_c = 16'h0030; exp_rd = fin_a;  end
                2:       begin fin_a = a & 20'hF8000; fin_c = 16'h0050; exp_rd = fin_a;  end
                default: begin fin_a = 20'h00555;     fin_c = 16'h0010; exp_rd = 20'h0; end
            endcase
            expq.push_back({20'h00555, 16'h00AA});
            expq.push_back({20'h002AA, 16'h0055});
            expq.push_back({20'h00555, 16'h0080});
            expq.push_back({20'h00555, 16'h00AA});
            expq.push_back({20'h002AA, 16'h0055});
            expq.push_back({fin_a, fin_c});
        end
        req_valid = 1'b1; req_op = op[1:0]; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        exp_busy  = 1'b1;
    endtask

    task automatic wait_done(input string tag);
        int start;
        int n;
        start = done_seen;
        n = 0;
        while (done_seen == start && n < 5000) begin
            @(negedge clk);
            #2;
            n++;
        end
        if (done_seen == start) begin
            chk(1'b0, tag, 0, 1);
            exp_busy = 0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(bus_req == 1'b0, "R1 bus idle after reset", bus_req, 0);
        chk(done == 1'b0, "R1 no done after reset", done, 0);
        rst_n = 1'b1;

        // R2 R9: plain program, read-back matches
        issue(0, 20'h01234, 16'h5A3C, 5, 0, "R2 program ok");
        wait_done("R9 program ok watchdog");

        // R9: programming a 0 bit back to 1 cannot succeed, read-back differs
        issue(0, 20'h01234, 16'hFFFF, 5, 1, "R9 read-back mismatch");
        wait_done("R9 mismatch watchdog");

        // R3 R10: sector erase then program the erased word
        issue(1, 20'h01234, 16'h0000, 12, 0, "R3 sector erase");
        wait_done("R10 sector erase watchdog");
        issue(0, 20'h01234, 16'hA5C3, 4, 0, "R9 program after erase");
        wait_done("R9 program after erase watchdog");

        // R3 R6: block erase, aligned base
        issue(1 + 1, 20'h4ABCD, 16'h0000, 9, 0, "R3 block erase");
        wait_done("R10 block erase watchdog");

        // R3 R6: chip erase, status at address 0
        issue(3, 20'h7FFFF, 16'h0000, 7, 0, "R3 chip erase");
        wait_done("R10 chip erase watchdog");

        // R7: a repeated status bit while busy must not end the wait
        glitch_at = 1;
        issue(0, 20'h00400, 16'h1234, 6, 0, "R7 confirm after false match");
        wait_done("R7 watchdog");
        glitch_at = -1;

        // R8: device never finishes
        stuck = 1;
        issue(1, 20'h02000, 16'h0000, 0, 1, "R8 timeout");
        wait_done("R8 watchdog");
        chk(n_reads == LIMIT, "R8 status read count", n_reads, LIMIT);
        stuck = 0;
        busy_left = 0;

        // R4: request held while busy is neither taken nor acted on
        issue(1, 20'h03000, 16'h0000, 30, 0, "R4 erase with held request");
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 20'h00010; req_data = 16'h0F0F;
        repeat (20) @(negedge clk);
        req_valid = 1'b0;
        wait_done("R4 watchdog");
        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R4 no leftover sequence", expq.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule